// File: doc/BRIEF.md
# SDRAM Maintenance Request Interlock

This block sits between software-visible control bits and an SDRAM command sequencer. Software asks for one of five maintenance operations: self-refresh, the initialization sequence, power-down, deep-power-down, or a mode register load. Each request carries a mask that picks one or both SDRAM channels. The block latches an accepted request and raises a one-hot command request toward the sequencer. It holds that request until the sequencer acknowledges that the command went out to the memory. While a request waits, a read-only busy bit for that operation stays at 1.

A busy bit stays set from the accepted write until the acknowledge. While any busy bit is set, every further maintenance write is dropped and a sticky error flag records the drop. If several operation bits arrive in one write while the block is idle, a fixed priority keeps exactly one of them. A qualifier bit travels with each request to tell the sequencer whether the request enters or leaves a low-power state. For deep-power-down, that means one busy bit covers both entry and recovery.

Top module: `sdram_maint_gate`

## Requirements
- R1: After reset, busyStat, cmdReq, cmdChan, cmdLeave and errFlag all read 0.
- R2: Operation bit positions in wrOps, busyStat and cmdReq are: 0 self-refresh, 1 initialization, 2 power-down, 3 deep-power-down, 4 mode register. Suppose all busy bits are 0 and a cycle has wrEn=1, at least one wrOps bit and at least one wrChan bit. Then on the next cycle exactly one busy bit reads 1, cmdReq equals busyStat, cmdChan equals the written mask and cmdLeave equals wrLeave.
- R3: When several wrOps bits are written together, the one kept is chosen in this order, highest first: initialization (bit 1), mode register (bit 4), self-refresh (bit 0), power-down (bit 2), deep-power-down (bit 3).
- R4: While cmdAck is 0, busyStat, cmdReq, cmdChan and cmdLeave hold their values.
- R5: cmdAck=1 while a request is pending clears busyStat and cmdReq on the next cycle, and cmdChan and cmdLeave then read 0. cmdAck while idle has no effect.
- R6: A write with wrEn=1 and any wrOps bit set, in a cycle where any busy bit is 1, is ignored. This includes the cycle that carries cmdAck. busyStat, cmdChan and cmdLeave are left as they were, so a new request is accepted no earlier than the cycle after the acknowledge.
- R7: Every write ignored under R6 sets errFlag on the next cycle. errFlag stays set until it is cleared.
- R8: errClr=1 clears errFlag on the next cycle. If the same cycle also sets the flag under R7, the flag stays set.
- R9: While idle, a write with no wrOps bit or no wrChan bit is a no-op: no busy bit is set and errFlag does not change.
- R10: At most one bit of cmdReq is ever 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Control write strobe |
| wrOps | input | 5 | Requested operation bits |
| wrChan | input | NUM_CH | Channel select mask |
| wrLeave | input | 1 | 1 = leave the low-power state, 0 = enter it |
| errClr | input | 1 | Write-1-to-clear for errFlag |
| cmdAck | input | 1 | Sequencer reports the command was issued |
| busyStat | output | 5 | Per-operation busy status |
| errFlag | output | 1 | Sticky ignored-write flag |
| cmdReq | output | 5 | One-hot command request to the sequencer |
| cmdChan | output | NUM_CH | Channels targeted by the pending request |
| cmdLeave | output | 1 | Enter/leave qualifier of the pending request |

## Verification
The bench builds the block with NUM_CH=2. At that size every combination of the five operation bits, the four channel masks and the qualifier can be driven from idle, which is 256 writes. Each write's expected winner comes from the priority order, and each accepted write is then held and acknowledged. For each of the five possible pending operations, the bench also sweeps all 31 non-zero operation patterns as writes that must be rejected. Directed cases cover a write in the acknowledge cycle, a set and a clear of the error flag in the same cycle, and an acknowledge with nothing pending.

// File: rtl/sdram_maint_pkg.sv
package sdram_maint_pkg;
  localparam int OP_N    = 5;
  localparam int OP_SREF = 0;
  localparam int OP_INIT = 1;
  localparam int OP_PWD  = 2;
  localparam int OP_DPD  = 3;
  localparam int OP_MRS  = 4;

  typedef logic [OP_N-1:0] opVec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   load;
    logic   clrBusy;
    logic   setErr;
    logic   clrErr;
    opVec_t pick;
  } strobe_t;

  // operation index held at a given priority rank, rank 0 highest
  function automatic int prioOp(input int rank);
    case (rank)
      0:       return OP_INIT;
      1:       return OP_MRS;
      2:       return OP_SREF;
      3:       return OP_PWD;
      default: return OP_DPD;
    endcase
  endfunction
endpackage

// File: rtl/sdram_maint_ctrl.sv
module sdram_maint_ctrl
  import sdram_maint_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              wrEn,
  input  opVec_t            wrOps,
  input  logic [NUM_CH-1:0] wrChan,
  input  logic              errClr,
  input  logic              cmdAck,
  input  logic              anyBusy,
  output strobe_t           stb
);
  logic [OP_N:0] taken;
  opVec_t        pickRaw;

  assign taken[0] = 1'b0;

  // priority chain, one stage per rank
  for (genvar r = 0; r < OP_N; r++) begin : g_rank
    assign pickRaw[prioOp(r)] = wrOps[prioOp(r)] & ~taken[r];
    assign taken[r+1]         = taken[r] | wrOps[prioOp(r)];
  end

  logic opWrite;

  always_comb begin
    opWrite     = wrEn && (|wrOps);
    stb.load    = opWrite && (|wrChan) && !anyBusy;
    stb.setErr  = opWrite && anyBusy;
    stb.clrBusy = cmdAck && anyBusy;
    stb.clrErr  = errClr;
    stb.pick    = pickRaw;
  end
endmodule

// File: rtl/sdram_maint_dp.sv
module sdram_maint_dp
  import sdram_maint_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [NUM_CH-1:0] wrChan,
  input  logic              wrLeave,
  output opVec_t            busyQ,
  output logic [NUM_CH-1:0] chanOut,
  output logic              leaveOut,
  output logic              errQ,
  output logic              anyBusy
);
  logic [NUM_CH-1:0] chanQ;
  logic              leaveQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= '0;
      chanQ  <= '0;
      leaveQ <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      if (stb.load) begin
        busyQ  <= stb.pick;
        chanQ  <= wrChan;
        leaveQ <= wrLeave;
      end else if (stb.clrBusy) begin
        busyQ <= '0;
      end
      if (stb.setErr)      errQ <= 1'b1;
      else if (stb.clrErr) errQ <= 1'b0;
    end
  end

  assign anyBusy  = |busyQ;
  assign chanOut  = anyBusy ? chanQ : '0;
  assign leaveOut = anyBusy & leaveQ;
endmodule

// File: rtl/sdram_maint_gate.sv
module sdram_maint_gate
  import sdram_maint_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [4:0]        wrOps,
  input  logic [NUM_CH-1:0] wrChan,
  input  logic              wrLeave,
  input  logic              errClr,
  input  logic              cmdAck,
  output logic [4:0]        busyStat,
  output logic              errFlag,
  output logic [4:0]        cmdReq,
  output logic [NUM_CH-1:0] cmdChan,
  output logic              cmdLeave
);
  strobe_t stb;
  logic    anyBusy;
  opVec_t  busyQ;

  sdram_maint_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .wrEn   (wrEn),
    .wrOps  (wrOps),
    .wrChan (wrChan),
    .errClr (errClr),
    .cmdAck (cmdAck),
    .anyBusy(anyBusy),
    .stb    (stb)
  );

  sdram_maint_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrChan  (wrChan),
    .wrLeave (wrLeave),
    .busyQ   (busyQ),
    .chanOut (cmdChan),
    .leaveOut(cmdLeave),
    .errQ    (errFlag),
    .anyBusy (anyBusy)
  );

  assign busyStat = busyQ;
  assign cmdReq   = busyQ;
endmodule

// File: rtl/sdram_maint_chk.sv
module sdram_maint_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [4:0]        wrOps,
  input logic [NUM_CH-1:0] wrChan,
  input logic              wrLeave,
  input logic              errClr,
  input logic              cmdAck,
  input logic [4:0]        busyStat,
  input logic              errFlag,
  input logic [4:0]        cmdReq,
  input logic [NUM_CH-1:0] cmdChan,
  input logic              cmdLeave
);
  p_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdReq));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busyStat == '0 && wrEn && (|wrOps) && (|wrChan))
    |=> ($onehot(busyStat) && cmdChan == $past(wrChan) && cmdLeave == $past(wrLeave)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((|cmdReq) && !cmdAck)
    |=> ($stable(cmdReq) && $stable(cmdChan) && $stable(cmdLeave)));

  p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((|cmdReq) && cmdAck) |=> (busyStat == '0 && cmdChan == '0));

  p_reject_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((|busyStat) && wrEn && (|wrOps) && !cmdAck) |=> $stable(busyStat));

  p_err_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((|busyStat) && wrEn && (|wrOps)) |=> errFlag);

  p_err_clr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (errClr && !((|busyStat) && wrEn && (|wrOps))) |=> !errFlag);

  p_noop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busyStat == '0 && !(wrEn && (|wrOps) && (|wrChan)))
    |=> (busyStat == '0 && errFlag == $past(errFlag && !errClr)));
endmodule

bind sdram_maint_gate sdram_maint_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrOps(wrOps), .wrChan(wrChan),
  .wrLeave(wrLeave), .errClr(errClr), .cmdAck(cmdAck), .busyStat(busyStat),
  .errFlag(errFlag), .cmdReq(cmdReq), .cmdChan(cmdChan), .cmdLeave(cmdLeave)
);

// File: tb/sdram_maint_gate_bench.sv
module sdram_maint_gate_bench;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rstN;
  logic           wrEn, wrLeave, errClr, cmdAck;
  logic [4:0]     wrOps;
  logic [NCH-1:0] wrChan;
  logic [4:0]     busyStat, cmdReq;
  logic           errFlag, cmdLeave;
  logic [NCH-1:0] cmdChan;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  sdram_maint_gate #(.NUM_CH(NCH)) u_sdram_maint_gate (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrOps(wrOps), .wrChan(wrChan),
    .wrLeave(wrLeave), .errClr(errClr), .cmdAck(cmdAck), .busyStat(busyStat),
    .errFlag(errFlag), .cmdReq(cmdReq), .cmdChan(cmdChan), .cmdLeave(cmdLeave)
  );

  // priority winner per R3: bit1, bit4, bit0, bit2, bit3
  function automatic logic [4:0] expPick(input logic [4:0] ops);
    int ord [5] = '{1, 4, 0, 2, 3};
    for (int i = 0; i < 5; i++)
      if (ops[ord[i]]) return 5'(1 << ord[i]);
    return 5'd0;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one cycle of inputs, then release and sample after the edge
  task automatic cycle(input logic en, input logic [4:0] ops, input logic [NCH-1:0] ch,
                       input logic lv, input logic clr, input logic ack);
    wrEn = en; wrOps = ops; wrChan = ch; wrLeave = lv; errClr = clr; cmdAck = ack;
    @(negedge clk);
    wrEn = 0; wrOps = 0; wrChan = 0; wrLeave = 0; errClr = 0; cmdAck = 0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 0; wrEn = 0; wrOps = 0; wrChan = 0; wrLeave = 0; errClr = 0; cmdAck = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    check("R1", "busyStat", busyStat, 0);
    check("R1", "cmdReq", cmdReq, 0);
    check("R1", "cmdChan", cmdChan, 0);
    check("R1", "cmdLeave", cmdLeave, 0);
    check("R1", "errFlag", errFlag, 0);

    // sweep every idle write pattern
    for (int op = 0; op < 32; op++)
      for (int ch = 0; ch < 4; ch++)
        for (int lv = 0; lv < 2; lv++) begin
          logic [4:0] exp;
          exp = (ch != 0) ? expPick(5'(op)) : 5'd0;
          cycle(1'b1, 5'(op), 2'(ch), 1'(lv), 1'b0, 1'b0);
          if (exp == 0) begin
            check("R9", "busyStat noop", busyStat, 0);
            check("R9", "errFlag noop", errFlag, 0);
          end else begin
            check("R3", "busyStat winner", busyStat, exp);
            check("R2", "cmdReq", cmdReq, exp);
            check("R2", "cmdChan", cmdChan, ch);
            check("R2", "cmdLeave", cmdLeave, lv);
            check("R10", "cmdReq ones", $countones(cmdReq), 1);
            cycle(1'b0, 5'd0, 2'd0, 1'b0, 1'b0, 1'b0);
            cycle(1'b0, 5'd0, 2'd0, 1'b0, 1'b0, 1'b0);
            check("R4", "cmdReq held", cmdReq, exp);
            check("R4", "cmdChan held", cmdChan, ch);
            cycle(1'b0, 5'd0, 2'd0, 1'b0, 1'b0, 1'b1);
            check("R5", "busyStat after ack", busyStat, 0);
            check("R5", "cmdChan after ack", cmdChan, 0);
            check("R5", "cmdLeave after ack", cmdLeave, 0);
            check("R9", "errFlag idle sweep", errFlag, 0);
          end
        end

    // rejection sweep for each pending operation
    for (int p = 0; p < 5; p++) begin
      cycle(1'b1, 5'(1 << p), 2'd1, 1'b1, 1'b0, 1'b0);
      for (int op = 1; op < 32; op++) begin
        cycle(1'b1, 5'(op), 2'd2, 1'b0, 1'b0, 1'b0);
        check("R6", "busyStat kept", busyStat, 1 << p);
        check("R6", "cmdChan kept", cmdChan, 1);
        check("R6", "cmdLeave kept", cmdLeave, 1);
        check("R7", "errFlag set", errFlag, 1);
      end
      cycle(1'b0, 5'd0, 2'd0, 1'b0, 1'b1, 1'b0);
      check("R8", "errFlag cleared", errFlag, 0);
      check("R8", "busy unaffected by clear", busyStat, 1 << p);
      cycle(1'b0, 5'd0, 2'd0, 1'b0, 1'b0, 1'b0);
      check("R7", "errFlag stays clear", errFlag, 0);
      // write in the acknowledge cycle
      cycle(1'b1, 5'd1, 2'd3, 1'b0, 1'b0, 1'b1);
      check("R6", "write at ack ignored", busyStat, 0);
      check("R7", "write at ack flagged", errFlag, 1);
      cycle(1'b0, 5'd0, 2'd0, 1'b0, 1'b1, 1'b0);
    end

    // set and clear of errFlag in the same cycle
    cycle(1'b1, 5'd4, 2'd1, 1'b0, 1'b0, 1'b0);
    cycle(1'b1, 5'd8, 2'd1, 1'b0, 1'b1, 1'b0);
    check("R8", "set wins over clear", errFlag, 1);
    check("R6", "busy kept", busyStat, 4);
    cycle(1'b0, 5'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    cycle(1'b1, 5'd16, 2'd2, 1'b1, 1'b1, 1'b0);
    check("R5", "accepted cycle after ack", busyStat, 16);
    check("R8", "clear applies", errFlag, 0);
    cycle(1'b0, 5'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    check("R5", "second ack clears", busyStat, 0);

    // acknowledge while idle
    cycle(1'b0, 5'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    check("R5", "idle ack busyStat", busyStat, 0);
    check("R5", "idle ack errFlag", errFlag, 0);
    cycle(1'b1, 5'd2, 2'd1, 1'b0, 1'b0, 1'b0);
    check("R2", "accept after idle ack", cmdReq, 2);

    finishRun();
  end
endmodule